// File: doc/BRIEF.md
# Serial Successive-Approximation Conversion Sequencer

This block is the digital sequencer inside a 12-bit sampling converter that talks to a host over three wires. The wires are a single control line (`ctl_i`), a bit clock (`bit_clk`) and a serial output that can be tri-stated (`sdo_o` with its enable `sdo_oe_o`). A parallel input, `decided_i`, stands in for the comparator and capacitor array: bit n of it is read while that bit is being sent. The control line is the only command input. Its level at particular points of the conversion selects sampling, holding, power-down, a second reversed-order burst, or an early abort.

All sequencing runs on the launching edge of `bit_clk`, the edge on which the serial bit changes. The control line may move at any time. It passes through a synchronizer of `SYNC_STAGES` flops, so the sequencer sees it two edges late at the default setting. The `hold_o` flag is the exception: it follows a low control line combinationally, with no clock edge needed.

The states are IDLE (sampling, full power), CONV (conversion cycles 1 to 13), REV (reversed burst), TAIL (output driven low, low power) and PDN (output off, low power). The transitions are:
- start: IDLE to CONV
- finish: CONV to IDLE
- sleep: CONV to PDN at the end of cycle 13
- abort: CONV to PDN before cycle 13
- reverse: CONV to REV
- drain: REV to TAIL
- wake: TAIL or PDN to IDLE

Top module: `sar_serial_seq`

## Requirements
- R1: While `rst_n` is low, the block is IDLE: `sdo_oe_o`=0, `sdo_o`=0 and `sleep_o`=0, and `hold_o` equals the inverse of `ctl_i`.
- R2: `hold_o` is 1 whenever `ctl_i` is 0, with no clock edge needed. It stays 1 in CONV, REV and TAIL regardless of `ctl_i`. It is 0 in IDLE and PDN while `ctl_i` is 1.
- R3: The synchronized control line lags `ctl_i` by two edges. When it falls while IDLE, CONV cycle 1 begins on the next edge, which is the third edge after the pin fell. In cycle 1, `sdo_oe_o`=1 and `sdo_o`=0.
- R4: In CONV cycle k (k from 2 to 13), `sdo_o` carries `decided_i[13-k]`: the most significant bit first, bit 0 in cycle 13. `sdo_o` is 0 whenever `sdo_oe_o` is 0.
- R5: Finish: suppose the synchronized line is never seen high in cycles 1 to 12 but is high at the end of cycle 13. Or suppose it was seen high in cycles 1 to 12 and is still high at the end of cycle 13. In both cases the block returns to IDLE with the output off and full power.
- R6: Sleep: if the synchronized line is low at the end of every cycle 1 to 13, the block enters PDN (`sleep_o`=1, output off). It stays there until the synchronized line is high, then wakes to IDLE.
- R7: Reverse: the synchronized line is seen high at the end of some cycle from 1 to 12, and it is low at the end of cycle 13. The next 11 cycles then send `decided_i[1]` up to `decided_i[11]`, one per cycle, with `sleep_o`=1.
- R8: After the reversed burst, the block holds TAIL (`sdo_oe_o`=1, `sdo_o`=0, `sleep_o`=1) until the synchronized line is high, then wakes to IDLE.
- R9: Abort: the synchronized line has been seen high in an earlier cycle, and is seen low at the end of a cycle from 1 to 12. The output is then off from the next cycle and the block is in PDN.
- R10: The first conversion after a sleep, an abort or a TAIL is a full, valid conversion, with no dummy cycle.
- R11: Control line activity is ignored during the reversed burst. A falling line only starts a conversion from IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| bit_clk | input | 1 | Bit clock; all state changes on its launching edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ctl_i | input | 1 | Asynchronous control line (high = sample/idle) |
| decided_i | input | 12 | Decided code bits from the converter core |
| sdo_o | output | 1 | Serial result bit |
| sdo_oe_o | output | 1 | Drive enable for the serial output buffer |
| hold_o | output | 1 | 1 = hold (input captured), 0 = sample |
| sleep_o | output | 1 | Low-power flag |

## Verification
The bench goes after the cycle boundaries where one level of the control line means different things. A rise seen in cycle 12 followed by a low line in cycle 13 must give the reversed burst. If the sequencer got that wrong, it would abort instead and turn the output off early. A low line seen in cycle 12 after an earlier rise must abort; a design that missed this would keep shifting bits after the host asked it to stop. The bench also checks that a control line left low from the start puts the block to sleep rather than back in IDLE. It checks that the reversed burst sends exactly 11 bits before the held-low tail. A bit index off by one would show up as a shifted code in either direction. Control line toggles during the burst must not disturb it.

// File: rtl/sar_seq_pkg.sv
`timescale 1ns/1ps
package sar_seq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_CONV = 3'd1,
        ST_REV  = 3'd2,
        ST_TAIL = 3'd3,
        ST_PDN  = 3'd4
    } seq_state_e;

endpackage

// File: rtl/sar_ctl_sync.sv
`timescale 1ns/1ps
module sar_ctl_sync #(
    parameter int STAGES = 2
) (
    input  logic bit_clk,
    input  logic rst_n,
    input  logic ctl_i,
    output logic ctl_s,
    output logic ctl_fall
);
    logic [STAGES-1:0] chain_q;
    logic              ctl_q;

    // Chain idles high: a released control line means sampling.
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '1;
            ctl_q   <= 1'b1;
        end else begin
            chain_q <= {chain_q[STAGES-2:0], ctl_i};
            ctl_q   <= chain_q[STAGES-1];
        end
    end

    assign ctl_s    = chain_q[STAGES-1];
    assign ctl_fall = ctl_q & ~chain_q[STAGES-1];
endmodule

// File: rtl/sar_bit_pick.sv
`timescale 1ns/1ps
module sar_bit_pick #(
    parameter int WIDTH = 12
) (
    input  logic [WIDTH-1:0]         code_i,
    input  logic [$clog2(WIDTH)-1:0] idx_i,
    output logic                     bit_o
);
    localparam int IW   = $clog2(WIDTH);
    localparam int PADW = 1 << IW;

    logic [PADW-1:0] padded;

    for (genvar g = 0; g < PADW; g++) begin : g_pad
        if (g < WIDTH) begin : g_live
            assign padded[g] = code_i[g];
        end else begin : g_zero
            assign padded[g] = 1'b0;
        end
    end

    assign bit_o = padded[idx_i];
endmodule

// File: rtl/sar_seq_fsm.sv
`timescale 1ns/1ps
module sar_seq_fsm
    import sar_seq_pkg::*;
#(
    parameter int WIDTH = 12
) (
    input  logic                     bit_clk,
    input  logic                     rst_n,
    input  logic                     ctl_i,
    input  logic                     ctl_s,
    input  logic                     ctl_fall,
    input  logic                     pick_bit,
    output logic [$clog2(WIDTH)-1:0] pick_idx,
    output logic                     sdo_o,
    output logic                     sdo_oe_o,
    output logic                     hold_o,
    output logic                     sleep_o
);
    localparam int CW = $clog2(WIDTH + 2);
    localparam int IW = $clog2(WIDTH);
    localparam logic [CW-1:0] ONE       = CW'(1);
    localparam logic [CW-1:0] LAST_CONV = CW'(WIDTH + 1);
    localparam logic [CW-1:0] LAST_REV  = CW'(WIDTH - 1);

    seq_state_e      state_q, state_d;
    logic [CW-1:0]   cnt_q, cnt_d;
    logic            raised_q, raised_d;
    logic [CW-1:0]   idx_full;
    logic            busy;

    // State register
    always_ff @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            cnt_q    <= '0;
            raised_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            cnt_q    <= cnt_d;
            raised_q <= raised_d;
        end
    end

    // Transitions
    always_comb begin
        state_d  = state_q;
        cnt_d    = cnt_q;
        raised_d = raised_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctl_fall) begin          // start
                    state_d  = ST_CONV;
                    cnt_d    = ONE;
                    raised_d = 1'b0;
                end
            end
            ST_CONV: begin
                if (cnt_q != LAST_CONV) begin
                    if (raised_q && !ctl_s) begin
                        state_d = ST_PDN;    // abort
                    end else begin
                        raised_d = raised_q | ctl_s;
                        cnt_d    = cnt_q + ONE;
                    end
                end else if (raised_q) begin
                    if (ctl_s) begin
                        state_d = ST_IDLE;   // finish
                    end else begin
                        state_d = ST_REV;    // reverse
                        cnt_d   = ONE;
                    end
                end else if (ctl_s) begin
                    state_d = ST_IDLE;       // finish
                end else begin
                    state_d = ST_PDN;        // sleep
                end
            end
            ST_REV: begin
                if (cnt_q == LAST_REV) begin
                    state_d = ST_TAIL;       // drain
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
            ST_TAIL, ST_PDN: begin
                if (ctl_s) begin
                    state_d = ST_IDLE;       // wake
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        idx_full = (state_q == ST_REV) ? cnt_q : (LAST_CONV - cnt_q);
        pick_idx = idx_full[IW-1:0];
        sdo_oe_o = 1'b0;
        sdo_o    = 1'b0;
        sleep_o  = 1'b0;
        busy     = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
            end
            ST_CONV: begin
                sdo_oe_o = 1'b1;
                busy     = 1'b1;
                sdo_o    = (cnt_q == ONE) ? 1'b0 : pick_bit;
            end
            ST_REV: begin
                sdo_oe_o = 1'b1;
                busy     = 1'b1;
                sleep_o  = 1'b1;
                sdo_o    = pick_bit;
            end
            ST_TAIL: begin
                sdo_oe_o = 1'b1;
                busy     = 1'b1;
                sleep_o  = 1'b1;
            end
            ST_PDN: begin
                sleep_o  = 1'b1;
            end
            default: begin
            end
        endcase
        hold_o = ~ctl_i | busy;
    end
endmodule

// File: rtl/sar_serial_seq.sv
`timescale 1ns/1ps
module sar_serial_seq #(
    parameter int WIDTH       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic             bit_clk,
    input  logic             rst_n,
    input  logic             ctl_i,
    input  logic [WIDTH-1:0] decided_i,
    output logic             sdo_o,
    output logic             sdo_oe_o,
    output logic             hold_o,
    output logic             sleep_o
);
    localparam int IW = $clog2(WIDTH);

    logic          ctl_s;
    logic          ctl_fall;
    logic          pick_bit;
    logic [IW-1:0] pick_idx;

    sar_ctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .bit_clk  (bit_clk),
        .rst_n    (rst_n),
        .ctl_i    (ctl_i),
        .ctl_s    (ctl_s),
        .ctl_fall (ctl_fall)
    );

    sar_bit_pick #(.WIDTH(WIDTH)) u_pick (
        .code_i (decided_i),
        .idx_i  (pick_idx),
        .bit_o  (pick_bit)
    );

    sar_seq_fsm #(.WIDTH(WIDTH)) u_fsm (
        .bit_clk  (bit_clk),
        .rst_n    (rst_n),
        .ctl_i    (ctl_i),
        .ctl_s    (ctl_s),
        .ctl_fall (ctl_fall),
        .pick_bit (pick_bit),
        .pick_idx (pick_idx),
        .sdo_o    (sdo_o),
        .sdo_oe_o (sdo_oe_o),
        .hold_o   (hold_o),
        .sleep_o  (sleep_o)
    );
endmodule

// File: rtl/sar_serial_seq_chk.sv
`timescale 1ns/1ps
module sar_serial_seq_chk (
    input logic bit_clk,
    input logic rst_n,
    input logic ctl_s,
    input logic sdo_o,
    input logic sdo_oe_o,
    input logic hold_o,
    input logic sleep_o
);
    // R3: a new drive burst opens with a low bit
    p_lead_low_r3: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(sdo_oe_o) |-> !sdo_o);

    // R4: nothing leaves on the serial line while the driver is off
    p_quiet_when_off_r4: assert property (@(posedge bit_clk) disable iff (!rst_n)
        !sdo_oe_o |-> !sdo_o);

    // R10: every conversion starts at full power
    p_start_full_power_r10: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $rose(sdo_oe_o) |-> !sleep_o);

    // R6: leaving low power needs the synchronized line high
    p_wake_on_ctl_r6: assert property (@(posedge bit_clk) disable iff (!rst_n)
        $fell(sleep_o) |-> $past(ctl_s));

    // R2: bits are only driven while the input is held
    p_hold_while_driving_r2: assert property (@(posedge bit_clk) disable iff (!rst_n)
        sdo_oe_o |-> hold_o);
endmodule

bind sar_serial_seq sar_serial_seq_chk chk_i (
    .bit_clk  (bit_clk),
    .rst_n    (rst_n),
    .ctl_s    (ctl_s),
    .sdo_o    (sdo_o),
    .sdo_oe_o (sdo_oe_o),
    .hold_o   (hold_o),
    .sleep_o  (sleep_o)
);

// File: tb/sar_serial_seq_tb_top.sv
`timescale 1ns/1ps
module sar_serial_seq_tb_top;
    localparam int W = 12;
    localparam int M_IDLE = 0, M_CONV = 1, M_REV = 2, M_TAIL = 3, M_PDN = 4;

    logic         bit_clk = 1'b0;
    logic         rst_n   = 1'b0;
    logic         ctl_i   = 1'b1;
    logic [W-1:0] decided_i = '0;
    logic         sdo_o, sdo_oe_o, hold_o, sleep_o;

    int  checks = 0;
    int  bad    = 0;
    bit  done   = 1'b0;

    // Reference view built from the requirements
    logic m_s1, m_s2, m_d;
    int   m_st, m_cnt;
    bit   m_raised, m_abort, m_woke;
    int   n_rev = 0, n_sleep = 0, n_abort = 0;

    always #10 bit_clk = ~bit_clk;

    sar_serial_seq #(.WIDTH(W)) dut_i (
        .bit_clk   (bit_clk),
        .rst_n     (rst_n),
        .ctl_i     (ctl_i),
        .decided_i (decided_i),
        .sdo_o     (sdo_o),
        .sdo_oe_o  (sdo_oe_o),
        .hold_o    (hold_o),
        .sleep_o   (sleep_o)
    );

    always @(posedge bit_clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= 1'b1; m_s2 <= 1'b1; m_d <= 1'b1;
            m_st <= M_IDLE; m_cnt <= 0; m_raised <= 1'b0;
            m_abort <= 1'b0; m_woke <= 1'b0;
        end else begin
            m_s1 <= ctl_i; m_s2 <= m_s1; m_d <= m_s2;
            case (m_st)
                M_IDLE: if (m_d && !m_s2) begin
                    m_st <= M_CONV; m_cnt <= 1; m_raised <= 1'b0;
                end
                M_CONV: begin
                    if (m_cnt <= W) begin
                        if (m_raised && !m_s2) begin
                            m_st <= M_PDN; m_abort <= 1'b1; n_abort++;
                        end else begin
                            if (m_s2) m_raised <= 1'b1;
                            m_cnt <= m_cnt + 1;
                        end
                    end else begin
                        m_woke <= 1'b0;
                        if (m_raised && !m_s2) begin
                            m_st <= M_REV; m_cnt <= 1; n_rev++;
                        end else if (m_s2) begin
                            m_st <= M_IDLE;
                        end else begin
                            m_st <= M_PDN; m_abort <= 1'b0; n_sleep++;
                        end
                    end
                end
                M_REV: if (m_cnt == W - 1) m_st <= M_TAIL; else m_cnt <= m_cnt + 1;
                default: if (m_s2) begin
                    m_st <= M_IDLE; m_woke <= 1'b1;
                end
            endcase
        end
    end

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    function automatic string tag_of();
        case (m_st)
            M_IDLE: return "R5";
            M_CONV: return (m_cnt == 1) ? "R3" : (m_woke ? "R10" : "R4");
            M_REV:  return m_s2 ? "R11" : "R7";
            M_TAIL: return "R8";
            default: return m_abort ? "R9" : "R6";
        endcase
    endfunction

    always @(negedge bit_clk) begin
        if (rst_n && !done) begin
            logic e_en, e_pw, e_dat;
            e_en  = (m_st == M_CONV) || (m_st == M_REV) || (m_st == M_TAIL);
            e_pw  = (m_st == M_REV) || (m_st == M_TAIL) || (m_st == M_PDN);
            e_dat = 1'b0;
            if (m_st == M_CONV && m_cnt > 1) e_dat = decided_i[W + 1 - m_cnt];
            if (m_st == M_REV)               e_dat = decided_i[m_cnt];
            chk(tag_of(), "sdo_oe", sdo_oe_o, e_en);
            chk(tag_of(), "sdo",    sdo_o,    e_dat);
            chk(tag_of(), "sleep",  sleep_o,  e_pw);
            chk("R2",     "hold",   hold_o,   !ctl_i || e_en);
        end
    end

    task automatic run(input logic v, input int n);
        ctl_i = v;
        decided_i = W'($urandom);
        repeat (n) @(negedge bit_clk);
        #2;
    endtask

    initial begin
        #3000000;
        if (!done) begin
            done = 1'b1;
            bad++; checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(negedge bit_clk);
        chk("R1", "sdo_oe", sdo_oe_o, 1'b0);
        chk("R1", "sdo",    sdo_o,    1'b0);
        chk("R1", "sleep",  sleep_o,  1'b0);
        chk("R1", "hold",   hold_o,   1'b0);
        #2 rst_n = 1'b1;
        run(1'b1, 5);
        // R2: hold follows a falling line without any clock edge
        ctl_i = 1'b0;
        #1 chk("R2", "hold immediate", hold_o, 1'b1);
        run(1'b0, 12); run(1'b1, 10);            // finish
        run(1'b0, 40); run(1'b1, 10);            // sleep, wake
        run(1'b0, 14); run(1'b1, 10);            // R10 full conversion after sleep
        run(1'b0, 6);  run(1'b1, 7);  run(1'b0, 30); run(1'b1, 10);  // reverse
        run(1'b0, 6);  run(1'b1, 7);  run(1'b0, 4);  run(1'b1, 2);
        run(1'b0, 20); run(1'b1, 10);            // R11 toggle inside burst
        run(1'b0, 6);  run(1'b1, 3);  run(1'b0, 20); run(1'b1, 10);  // abort
        for (int i = 0; i < 600; i++) begin
            run(1'($urandom), int'($urandom_range(1, 16)));
        end
        run(1'b1, 10);
        chk("R7", "reverse burst reached", n_rev > 0, 1'b1);
        chk("R6", "sleep reached",         n_sleep > 0, 1'b1);
        chk("R9", "abort reached",         n_abort > 0, 1'b1);
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", checks, bad);
            $finish;
        end
    end
endmodule